// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is the master end of a three-wire-plus-frame serial link. It divides the system clock down to a serial clock, marks the start of every word with a frame pulse that lasts one serial period, and shifts words out most significant bit first. At the same time it shifts in the word returned by the slave. Words come from a transmit FIFO through a valid/ready pop. Received words leave through a one-cycle push strobe toward a receive FIFO, which reports back when it is full.

The word length is programmable from 4 to 32 bits. Transmit words are taken from the low-order bits of the data input. While the FIFO keeps supplying words, frames run back to back: the frame pulse for the next word is raised during the last bit of the current word, and the next MSB follows the current LSB with no idle period. When the supply runs out, the port finishes the frame. It then runs one more serial period so the last received word can be pushed, after which the serial clock stops low. A configuration input chooses what the data line does after the final word: hold the last bit, or return low.

Top module: `fpss_master`

## Requirements
- R1: The serial clock idles low. It runs only while a frame is pending or in progress. Each of its high and low phases lasts `clk_div_i` system clock cycles, and a value of 0 is treated as 1. The first rising edge comes `clk_div_i` cycles after transmit data becomes valid in idle.
- R2: The frame pulse rises together with a serial clock rising edge and stays high for exactly one serial period. The first data bit of that word is driven at the next rising edge.
- R3: The transmit line and the frame pulse change only at serial clock rising edges. Data is sent MSB first.
- R4: `word_len_i` sets the word length, and values from 4 to 32 are valid. Only bits [len-1:0] of `tx_data_i` are sent, and only len bits are assembled per received word. Received words are right-aligned, and the unused upper bits read as 0.
- R5: While `tx_valid_i` stays high, the frame pulse for the next word shares the LSB period of the current word, and the next MSB directly follows that LSB.
- R6: `rxd_i` is sampled on the serial clock falling edge of each data bit. The word is assembled MSB first and pushed through `rx_valid_o`, a pulse one system cycle long. The push comes on the first rising edge after the word's last bit has been sampled.
- R7: After the final word, one more serial period runs. During it and afterwards, `txd_o` holds the LSB if `hold_last_i`=1, or drives 0 if `hold_last_i`=0. The frame pulse is 0 during that period.
- R8: While `enable_i` is low or `rst_ni` is low, `sclk_o`, `fsync_o` and `txd_o` are low, any frame in progress is abandoned, and `rx_overrun_o` is cleared.
- R9: If `rx_full_i` is high when a word would be pushed, the word is dropped, no `rx_valid_o` pulse occurs, and `rx_overrun_o` goes high and stays high until the port is disabled.
- R10: `tx_ready_o` is high for one system cycle, in the cycle before the rising edge that starts a frame pulse. A word is popped only when `tx_valid_i` is also high. Exactly one pop occurs per transmitted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Port enable; low clears the port synchronously |
| hold_last_i | input | 1 | 1: keep the last bit on txd after the final word; 0: drive low |
| word_len_i | input | LEN_W | Bits per word, 4 to DATA_W |
| clk_div_i | input | DIV_W | Serial clock half period in system cycles |
| tx_data_i | input | DATA_W | Word offered by the transmit FIFO |
| tx_valid_i | input | 1 | Transmit FIFO holds a word |
| tx_ready_o | output | 1 | Pop strobe toward the transmit FIFO |
| rx_data_o | output | DATA_W | Received word, right-aligned |
| rx_valid_o | output | 1 | Push strobe toward the receive FIFO |
| rx_full_i | input | 1 | Receive FIFO cannot accept a word |
| rx_overrun_o | output | 1 | Sticky: a received word was dropped |
| sclk_o | output | 1 | Serial clock |
| fsync_o | output | 1 | Frame pulse |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
The bench builds the expected serial clock, frame and data waveform for every system cycle of each burst and compares all three on every cycle. A wrong divider count, a frame pulse that lasts too long, an LSB-first shift or a dead period between back-to-back words therefore shows up as a mismatch at the first cycle it occurs. Word lengths of 4, 5, 12 and 32 are used, and transmit words carry junk above the length, so a design that shifts from the wrong bit sends junk or drops the MSB. The slave model returns its own words, and the bench compares the pushed words and counts them. A design that pushes one edge early loses the LSB, and one that pushes while the receive FIFO is full shows a strobe where none is allowed. Both tail settings are run, and a burst is cut off by disabling the port mid-frame. A design that leaves the line high or keeps the overrun flag after disable is caught by the check that follows.

// File: rtl/fpss_pkg.sv
package fpss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_TAIL,
    ST_STOP
  } fpss_state_e;
endpackage

// File: rtl/fpss_sclk_gen.sv
module fpss_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             tick;

  assign lim    = (half_i == '0) ? DIV_W'(1) : half_i;
  assign tick   = run_i && (cnt_q == lim - DIV_W'(1));
  assign rise_o = tick && !sclk_o;
  assign fall_o = tick && sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/fpss_tx.sv
module fpss_tx #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              shift_i,
  input  logic              load_i,
  input  logic              tail_i,
  input  logic              hold_last_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o
);
  logic [DATA_W-1:0] sh_q;
  logic [LEN_W-1:0]  pad;

  // left-justify so the word MSB sits at the top of the shifter
  assign pad = LEN_W'(DATA_W) - len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      txd_o <= 1'b0;
    end else if (clr_i) begin
      sh_q  <= '0;
      txd_o <= 1'b0;
    end else if (rise_i) begin
      if (shift_i) begin
        txd_o <= sh_q[DATA_W-1];
        sh_q  <= sh_q << 1;
      end else if (tail_i && !hold_last_i) begin
        txd_o <= 1'b0;
      end
      // load during the frame pulse period, overriding the shift on the LSB edge
      if (load_i) sh_q <= data_i << pad;
    end
  end
endmodule

// File: rtl/fpss_rx.sv
module fpss_rx #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              arm_i,
  input  logic              rxd_i,
  input  logic              full_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W:0]   mask_ext;
  logic [LEN_W-1:0]  cnt_q;
  logic              pend_q;
  logic              done_q;

  assign mask_ext = ((DATA_W+1)'(1) << len_i) - (DATA_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else if (clr_i) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fall_i && pend_q) begin
        sh_q <= {sh_q[DATA_W-2:0], rxd_i};
        if (cnt_q == len_i - LEN_W'(1)) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
      end
      if (rise_i) begin
        pend_q <= arm_i;
        if (done_q) begin
          done_q <= 1'b0;
          if (full_i) begin
            overrun_o <= 1'b1;
          end else begin
            valid_o <= 1'b1;
            data_o  <= sh_q & mask_ext[DATA_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/fpss_master.sv
module fpss_master
  import fpss_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DIV_W  = 8,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              hold_last_i,
  input  logic [LEN_W-1:0]  word_len_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_full_i,
  output logic              rx_overrun_o,
  output logic              sclk_o,
  output logic              fsync_o,
  output logic              txd_o,
  input  logic              rxd_i
);
  fpss_state_e      state_q;
  logic [LEN_W-1:0] bits_q;
  logic [LEN_W-1:0] len;
  logic             run, rise, fall, last_bit, pop, in_data;

  assign len = (word_len_i < LEN_W'(4))      ? LEN_W'(4) :
               (word_len_i > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : word_len_i;

  assign run        = enable_i && (state_q != ST_IDLE);
  assign in_data    = (state_q == ST_DATA);
  assign last_bit   = in_data && (bits_q == LEN_W'(1));
  assign tx_ready_o = enable_i && rise && ((state_q == ST_START) || last_bit);
  assign pop        = tx_ready_o && tx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      fsync_o <= 1'b0;
    end else if (!enable_i) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      fsync_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (tx_valid_i) state_q <= ST_START;
        ST_START: if (rise) begin
          if (pop) begin
            fsync_o <= 1'b1;
            bits_q  <= len;
            state_q <= ST_DATA;
          end else begin
            state_q <= ST_STOP;
          end
        end
        ST_DATA: if (rise) begin
          fsync_o <= 1'b0;
          bits_q  <= bits_q - LEN_W'(1);
          if (last_bit) begin
            if (pop) begin
              fsync_o <= 1'b1;
              bits_q  <= len;
            end else begin
              state_q <= ST_TAIL;
            end
          end
        end
        ST_TAIL: if (rise) state_q <= ST_STOP;
        ST_STOP: if (fall) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fpss_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (clk_div_i),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  fpss_tx #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (!enable_i),
    .rise_i      (rise),
    .shift_i     (in_data),
    .load_i      (pop),
    .tail_i      (state_q == ST_TAIL),
    .hold_last_i (hold_last_i),
    .len_i       (len),
    .data_i      (tx_data_i),
    .txd_o       (txd_o)
  );

  fpss_rx #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!enable_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .arm_i     (in_data),
    .rxd_i     (rxd_i),
    .full_i    (rx_full_i),
    .len_i     (len),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .overrun_o (rx_overrun_o)
  );

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sclk_o);

  p_fsync_on_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fsync_o) |-> $rose(sclk_o));

  p_fsync_one_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && $past(fsync_o)) |-> !fsync_o);

  p_txd_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && $past(enable_i) && !$stable(txd_o)) |-> $rose(sclk_o));

  p_push_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $rose(sclk_o));

  p_quiet_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!txd_o && !sclk_o && !fsync_o));

  p_overrun_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rx_overrun_o) && $past(enable_i)) |-> rx_overrun_o);

  p_pop_frames_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && tx_valid_i) |=> (fsync_o && sclk_o));
endmodule

// File: tb/fpss_master_test.sv
`timescale 1ns/1ps
module fpss_master_test;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              enable_i = 1'b0;
  logic              hold_last_i = 1'b0;
  logic [LEN_W-1:0]  word_len_i = 6'd8;
  logic [DIV_W-1:0]  clk_div_i = 8'd1;
  logic [DATA_W-1:0] tx_data_i = '0;
  logic              tx_valid_i = 1'b0;
  logic              tx_ready_o;
  logic [DATA_W-1:0] rx_data_o;
  logic              rx_valid_o;
  logic              rx_full_i = 1'b0;
  logic              rx_overrun_o;
  logic              sclk_o, fsync_o, txd_o;
  logic              rxd_i = 1'b0;

  int  checks = 0;
  int  fails  = 0;
  int  seed   = 1;
  bit  done   = 0;
  logic prev_t = 1'b0;

  always #4 clk = ~clk;

  fpss_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .hold_last_i(hold_last_i),
    .word_len_i(word_len_i), .clk_div_i(clk_div_i), .tx_data_i(tx_data_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o), .rx_full_i(rx_full_i), .rx_overrun_o(rx_overrun_o),
    .sclk_o(sclk_o), .fsync_o(fsync_o), .txd_o(txd_o), .rxd_i(rxd_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // behavioural model of one burst: expected waveform per system cycle
  task automatic run_burst(input int n, input int L, input int D, input bit hold,
                           input bit full, input string tag);
    logic [2:0]  q[$];
    logic [31:0] tw[8];
    logic [31:0] rw[8];
    logic [31:0] mask;
    logic [2:0]  e, a;
    logic        f, t, tail_t;
    int ti, ri, p, j, b;
    bit pend, prev_s;
    mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
    for (int k = 0; k < n; k++) begin
      tw[k] = (32'h9E37_79B9 * (seed + k)) ^ 32'h5A5A_0F0F;
      rw[k] = (32'h85EB_CA6B * (seed + k + 7)) ^ 32'hC3C3_3C3C;
    end
    seed += n + 3;
    tail_t = hold ? tw[n-1][0] : 1'b0;
    for (int c = 0; c < D; c++) q.push_back({1'b0, 1'b0, prev_t});
    for (int pp = 0; pp <= n*L + 1; pp++) begin
      if (pp == 0) begin
        f = 1'b1; t = prev_t;
      end else if (pp <= n*L) begin
        j = (pp-1) / L; b = L - 1 - ((pp-1) % L);
        t = tw[j][b]; f = (b == 0) && (j < n-1);
      end else begin
        f = 1'b0; t = tail_t;
      end
      for (int c = 0; c < D; c++) q.push_back({1'b1, f, t});
      for (int c = 0; c < D; c++) q.push_back({1'b0, f, t});
    end
    word_len_i = LEN_W'(L); clk_div_i = DIV_W'(D); hold_last_i = hold; rx_full_i = full;
    tx_data_i = tw[0]; tx_valid_i = 1'b1;
    ti = 0; ri = 0; p = -1; pend = 0; prev_s = 0;
    while (q.size() > 0) begin
      @(negedge clk);
      if (pend) begin
        ti++; pend = 0;
        if (ti < n) tx_data_i = tw[ti]; else tx_valid_i = 1'b0;
      end
      e = q.pop_front();
      a = {sclk_o, fsync_o, txd_o};
      chk(a === e, {tag, " R1 R2 R3 R5 R7 waveform {sclk,fsync,txd}"}, 32'(a), 32'(e));
      if (tx_valid_i && tx_ready_o) pend = 1;
      if (sclk_o && !prev_s) begin
        p++;
        if (p >= 1 && p <= n*L) begin
          j = (p-1) / L; b = L - 1 - ((p-1) % L);
          rxd_i = rw[j][b];
        end else begin
          rxd_i = 1'b0;
        end
      end
      prev_s = sclk_o;
      if (rx_valid_o) begin
        chk(!full && ri < n, {tag, " R9 no push while full"}, 32'(ri), 32'(n));
        if (ri < n) chk(rx_data_o === (rw[ri] & mask), {tag, " R6 R4 received word"}, rx_data_o, rw[ri] & mask);
        ri++;
      end
    end
    prev_t = tail_t;
    for (int c = 0; c < 2*D + 2; c++) begin
      @(negedge clk);
      chk({sclk_o, fsync_o, txd_o} === {2'b00, prev_t}, {tag, " R1 R7 idle after burst"},
          32'({sclk_o, fsync_o, txd_o}), 32'({2'b00, prev_t}));
    end
    chk(ti == n, {tag, " R10 one pop per word"}, 32'(ti), 32'(n));
    chk(ri == (full ? 0 : n), {tag, " R6 push count"}, 32'(ri), full ? 32'd0 : 32'(n));
    if (full) chk(rx_overrun_o === 1'b1, {tag, " R9 overrun set"}, 32'(rx_overrun_o), 32'd1);
    rx_full_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({sclk_o, fsync_o, txd_o, tx_ready_o, rx_valid_o, rx_overrun_o} === 6'b0,
        "R8 reset state", 32'({sclk_o, fsync_o, txd_o, tx_ready_o, rx_valid_o, rx_overrun_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    enable_i = 1'b1;
    @(negedge clk);

    // R1 R10: no data, no clock, no pop
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      chk(!sclk_o && !tx_ready_o, "R1 R10 idle without data", 32'({sclk_o, tx_ready_o}), 32'd0);
    end

    run_burst(1, 8, 1, 1'b1, 1'b0, "single L8");
    run_burst(3, 4, 2, 1'b0, 1'b0, "b2b L4");
    run_burst(2, 32, 1, 1'b1, 1'b0, "b2b L32 R4");
    run_burst(2, 5, 3, 1'b0, 1'b1, "full L5");
    run_burst(1, 6, 1, 1'b1, 1'b0, "after full");
    chk(rx_overrun_o === 1'b1, "R9 overrun sticky", 32'(rx_overrun_o), 32'd1);

    // R8: disable mid-frame with an all-ones word
    word_len_i = 6'd8; clk_div_i = 8'd2; hold_last_i = 1'b1;
    tx_data_i = 32'hFFFF_FFFF; tx_valid_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(txd_o === 1'b1, "R3 all-ones word on line", 32'(txd_o), 32'd1);
    enable_i = 1'b0; tx_valid_i = 1'b0;
    @(negedge clk);
    chk({sclk_o, fsync_o, txd_o, rx_overrun_o} === 4'b0, "R8 disabled outputs low, overrun cleared",
        32'({sclk_o, fsync_o, txd_o, rx_overrun_o}), 32'd0);
    repeat (5) @(negedge clk);
    chk({sclk_o, txd_o} === 2'b0, "R8 stays low while disabled", 32'({sclk_o, txd_o}), 32'd0);
    enable_i = 1'b1;
    prev_t = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sclk_o, "R1 restart idle", 32'(sclk_o), 32'd0);

    run_burst(4, 12, 2, 1'b1, 1'b0, "re-enabled b2b L12");
    summary();
  end
endmodule